// File: doc/BRIEF.md
# Host Interrupt Collector

This block gathers single-cycle event pulses from several producers, filters each one through a per-source enable bit, and keeps a record of which enabled sources fired. While any recorded source bit is set, it holds a level interrupt request to the host. The producers are the handshake lines of each processing element, plus five fixed sources: step-counter done, countdown done, readback done, over-current and DMA done. The block detects falling edges on the handshake lines itself. The other sources arrive as ready-made one-cycle pulses.

The host sees one 32-bit word. Bits 14:0 hold the enables and bits 30:16 hold the status, and both fields use the same source layout. Bit 31 is a write-only qualifier. A write with the qualifier set reprograms the enables. A write with the qualifier clear is an acknowledge: it clears the status and drops the request in a single access, and it leaves the enables alone.

Source bit layout: bit `2*p+b` is handshake bit `b` of element `p`, so bits 0 to 5 cover the default of three elements with two lines each. After those come bit 6 step done, bit 7 countdown done, bit 8 readback done, bit 9 over-current and bit 10 DMA done. Bits 11 to 14 are reserved.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset, every enable bit and every status bit is 0, the read word is 0 and `irq` is low.
- R2: An event whose enable bit is 0 sets no status bit and does not raise `irq`.
- R3: A write with bit 31 = 1 loads the enables from `wr_data[10:0]` on the next cycle. The reserved enable bits 14:11 always read 0.
- R4: A write with bit 31 = 0 leaves the enables unchanged and clears all status bits, so `irq` falls on the next cycle.
- R5: The read word is {0, status[14:0], 0, enable[14:0]} from bit 31 down. Bit 31 and bit 15 always read 0.
- R6: An enabled event sets its status bit one cycle after the pulse. Status bits accumulate until an acknowledge, and `irq` is high exactly while any status bit is set.
- R7: If an enabled event arrives in the same cycle as an acknowledge, its status bit is set after that cycle and `irq` stays high.
- R8: A handshake line produces an event only on a high-to-low change, and only while its interrupt-mode bit is 1 and its output-enable bit is 0. A rising change, a steady level, a line with output enable on, or a line not in interrupt mode produces nothing.
- R9: The fixed sources map to status bits 6 (step done), 7 (countdown done), 8 (readback done), 9 (over-current) and 10 (DMA done). Handshake line `2*p+b` maps to bit `2*p+b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_line | input | NUM_PE*HS_PER_PE | Handshake line levels, index 2*p+b |
| hs_oe | input | NUM_PE*HS_PER_PE | Per-line output enable; 1 disables edge events |
| hs_irq_mode | input | NUM_PE*HS_PER_PE | Per-line interrupt-mode select |
| step_done | input | 1 | Step-counter completion pulse |
| count_done | input | 1 | Countdown completion pulse |
| rdbk_done | input | 1 | Readback completion pulse |
| overcurrent | input | 1 | Over-current event pulse |
| dma_done | input | 1 | DMA completion pulse |
| wr_en | input | 1 | Host write strobe for the register |
| wr_data | input | 32 | Host write data; bit 31 selects enable load or acknowledge |
| rd_data | output | 32 | Register read word |
| irq | output | 1 | Level interrupt request to the host |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same clock as a fresh enabled event. Closely related is an enable reprogram that lands in the same clock as an event, where the event must still be judged against the old enables. Directed steps place the write strobe and the event pulse on the same negative edge so that both reach the same clock. A long random phase then keeps writes and pulses dense enough for these collisions to recur, and it also toggles the handshake line levels, modes and output enables in every combination. A behavioural model updated on each rising edge is compared against the read word and `irq` on every falling edge.

// File: rtl/irq_reg_pkg.sv
package irq_reg_pkg;
  localparam int SRC_W    = 15;
  localparam int REG_W    = 32;
  localparam int QUAL_BIT = 31;
  localparam int STAT_LSB = 16;
  localparam int FIXED_SRC = 5;

  typedef logic [SRC_W-1:0] src_vec_t;

  // Offsets of the fixed sources past the handshake lines.
  typedef enum int {
    OFS_STEP  = 0,
    OFS_COUNT = 1,
    OFS_RDBK  = 2,
    OFS_OVC   = 3,
    OFS_DMA   = 4
  } fixed_src_e;

  // Acknowledge replaces the record with this cycle's events; otherwise accumulate.
  function automatic src_vec_t next_status(src_vec_t cur, src_vec_t ev_masked, logic ack);
    return ack ? ev_masked : (cur | ev_masked);
  endfunction

  function automatic logic [REG_W-1:0] pack_read(src_vec_t en, src_vec_t st);
    return {1'b0, st, 1'b0, en};
  endfunction
endpackage

// File: rtl/hs_edge_detect.sv
module hs_edge_detect #(
  parameter int LINES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line,
  input  logic [LINES-1:0] oe,
  input  logic [LINES-1:0] irq_mode,
  output logic [LINES-1:0] fall_ev
);
  logic [LINES-1:0] line_q;

  // Reset to 0 so a line held low out of reset never looks like a fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic armed;
    assign armed      = irq_mode[i] & ~oe[i];
    assign fall_ev[i] = armed & line_q[i] & ~line[i];

    assert_no_rise_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (line[i] && $past(line[i]) == 1'b0) |-> !fall_ev[i]);
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_reg_pkg::*;
#(
  parameter int USED_SRC = 11
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t src_ev,
  input  logic     wr_en,
  input  logic     wr_qual,
  input  src_vec_t wr_en_data,
  output src_vec_t en_q,
  output src_vec_t st_q
);
  localparam src_vec_t IMPL_MASK = {SRC_W{1'b1}} >> (SRC_W - USED_SRC);

  src_vec_t ev_masked;
  logic     ack;
  logic     load_en;

  assign ev_masked = src_ev & en_q;
  assign ack       = wr_en & ~wr_qual;
  assign load_en   = wr_en & wr_qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      st_q <= next_status(st_q, ev_masked, ack);
      if (load_en) en_q <= wr_en_data & IMPL_MASK;
    end
  end

  assert_masked_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

  assert_enable_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_qual) |=> (en_q == ($past(wr_en_data) & IMPL_MASK)));

  assert_ack_keeps_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_qual) |=> $stable(en_q));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_qual) |=> (st_q == $past(src_ev & en_q)));
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import irq_reg_pkg::*;
#(
  parameter int NUM_PE    = 3,
  parameter int HS_PER_PE = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PE*HS_PER_PE-1:0]   hs_line,
  input  logic [NUM_PE*HS_PER_PE-1:0]   hs_oe,
  input  logic [NUM_PE*HS_PER_PE-1:0]   hs_irq_mode,
  input  logic                          step_done,
  input  logic                          count_done,
  input  logic                          rdbk_done,
  input  logic                          overcurrent,
  input  logic                          dma_done,
  input  logic                          wr_en,
  input  logic [REG_W-1:0]              wr_data,
  output logic [REG_W-1:0]              rd_data,
  output logic                          irq
);
  localparam int HS_LINES = NUM_PE * HS_PER_PE;
  localparam int USED_SRC = HS_LINES + FIXED_SRC;

  logic [HS_LINES-1:0] hs_fall;
  src_vec_t            src_ev;
  src_vec_t            en_q;
  src_vec_t            st_q;
  logic                unused_wr_bits;

  assign unused_wr_bits = ^wr_data[QUAL_BIT-1:SRC_W];

  hs_edge_detect #(.LINES(HS_LINES)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .line     (hs_line),
    .oe       (hs_oe),
    .irq_mode (hs_irq_mode),
    .fall_ev  (hs_fall)
  );

  always_comb begin
    src_ev = '0;
    src_ev[HS_LINES-1:0]        = hs_fall;
    src_ev[HS_LINES + OFS_STEP]  = step_done;
    src_ev[HS_LINES + OFS_COUNT] = count_done;
    src_ev[HS_LINES + OFS_RDBK]  = rdbk_done;
    src_ev[HS_LINES + OFS_OVC]   = overcurrent;
    src_ev[HS_LINES + OFS_DMA]   = dma_done;
  end

  irq_status_reg #(.USED_SRC(USED_SRC)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_ev     (src_ev),
    .wr_en      (wr_en),
    .wr_qual    (wr_data[QUAL_BIT]),
    .wr_en_data (wr_data[SRC_W-1:0]),
    .en_q       (en_q),
    .st_q       (st_q)
  );

  assign rd_data = pack_read(en_q, st_q);
  assign irq     = |st_q;

  assert_irq_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(src_ev & en_q) != '0));

  assert_ack_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[QUAL_BIT] && (src_ev & en_q) == '0) |=> !irq);

  assert_hs_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q[HS_LINES-1:0] & ~$past(st_q[HS_LINES-1:0]) &
      ~$past(hs_irq_mode & ~hs_oe)) == '0));
endmodule

// File: tb/host_irq_ctrl_tb.sv
module host_irq_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  hs_line = 6'h3F;
  logic [5:0]  hs_oe = 6'h00;
  logic [5:0]  hs_mode = 6'h3F;
  logic        step_done = 0, count_done = 0, rdbk_done = 0, overcurrent = 0, dma_done = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  host_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hs_line(hs_line), .hs_oe(hs_oe), .hs_irq_mode(hs_mode),
    .step_done(step_done), .count_done(count_done), .rdbk_done(rdbk_done),
    .overcurrent(overcurrent), .dma_done(dma_done), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  // Behavioural reference model
  logic [14:0] m_en = '0, m_st = '0;
  logic [5:0]  m_prev = '0;

  always @(posedge clk) begin
    logic [14:0] ev;
    if (!rst_n) begin
      m_en = '0; m_st = '0; m_prev = '0;
    end else begin
      ev = '0;
      for (int i = 0; i < 6; i++)
        if (m_prev[i] == 1 && hs_line[i] == 0 && hs_mode[i] == 1 && hs_oe[i] == 0) ev[i] = 1;
      ev[6] = step_done; ev[7] = count_done; ev[8] = rdbk_done;
      ev[9] = overcurrent; ev[10] = dma_done;
      ev = ev & m_en;
      if (wr_en && wr_data[31] == 0) m_st = ev;
      else m_st = m_st | ev;
      if (wr_en && wr_data[31] == 1) m_en = wr_data[14:0] & 15'h07FF;
      m_prev = hs_line;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({cur_req, " model word"}, rd_data, {1'b0, m_st, 1'b0, m_en});
    chk({cur_req, " model irq"}, {31'b0, irq}, {31'b0, (m_st != 0)});
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d;
  endtask

  task automatic idle();
    wr_en = 0; wr_data = '0;
    step_done = 0; count_done = 0; rdbk_done = 0; overcurrent = 0; dma_done = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; tick();
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    cur_req = "R2"; step_done = 1; tick(); idle(); tick();
    chk("R2 disabled event ignored", rd_data, 32'h0);

    cur_req = "R3"; wr(32'h8000_7FFF); tick(); idle(); tick();
    chk("R3 R5 enable load, reserved and qualifier read 0", rd_data, 32'h0000_07FF);

    cur_req = "R9"; count_done = 1; tick(); idle();
    chk("R9 countdown bit 7", rd_data, 32'h0080_07FF);
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    dma_done = 1; tick(); idle();
    chk("R6 R9 accumulate dma bit 10", rd_data, 32'h0480_07FF);

    cur_req = "R4"; wr(32'h0000_0000); tick(); idle();
    chk("R4 ack clears status keeps enables", rd_data, 32'h0000_07FF);
    chk("R4 irq low", {31'b0, irq}, 32'h0);

    cur_req = "R7"; step_done = 1; tick(); idle();
    wr(32'h0000_0000); rdbk_done = 1; tick(); idle();
    chk("R7 event wins over same-cycle ack", rd_data, 32'h0100_07FF);
    chk("R7 irq stays", {31'b0, irq}, 32'h1);
    wr(32'h0); tick(); idle();

    cur_req = "R2"; wr(32'h8000_0200); tick(); idle();
    step_done = 1; tick(); idle();
    chk("R2 step masked", rd_data, 32'h0000_0200);
    overcurrent = 1; tick(); idle();
    chk("R9 overcurrent bit 9", rd_data, 32'h0200_0200);
    wr(32'h0); tick(); idle();

    cur_req = "R3"; wr(32'h8000_0000); step_done = 1; tick(); idle();
    chk("R3 R2 same-cycle reload with masked event", rd_data, 32'h0000_0000);
    wr(32'h8000_0040); step_done = 1; tick(); idle();
    chk("R3 event judged on old enables", rd_data, 32'h0000_0040);
    wr(32'h8000_07FF); step_done = 1; tick(); idle();
    chk("R3 R9 reload with event under old enable", rd_data, 32'h0040_07FF);
    wr(32'h0); tick(); idle();

    cur_req = "R8"; hs_line = 6'h37; tick();
    chk("R8 fall on line 3", rd_data, 32'h0008_07FF);
    wr(32'h0); tick(); idle(); tick();
    chk("R8 steady low no event", rd_data, 32'h0000_07FF);
    hs_line = 6'h3F; tick();
    chk("R8 rise no event", rd_data, 32'h0000_07FF);
    hs_oe = 6'h01; hs_line = 6'h3E; tick();
    chk("R8 output enabled no event", rd_data, 32'h0000_07FF);
    hs_mode = 6'h1F; hs_line = 6'h1E; tick();
    chk("R8 non-interrupt mode no event", rd_data, 32'h0000_07FF);
    hs_oe = 0; hs_mode = 6'h3F; hs_line = 6'h3F; tick();
    hs_line = 6'h1F; tick();
    chk("R8 fall on line 5", rd_data, 32'h0020_07FF);
    wr(32'h0); tick(); idle();

    cur_req = "R6";
    for (int n = 0; n < 600; n++) begin
      hs_line = 6'($urandom); hs_oe = 6'($urandom & $urandom);
      hs_mode = 6'($urandom | $urandom);
      step_done = ($urandom % 6) == 0; count_done = ($urandom % 6) == 0;
      rdbk_done = ($urandom % 6) == 0; overcurrent = ($urandom % 6) == 0;
      dma_done = ($urandom % 6) == 0;
      wr_en = ($urandom % 4) == 0;
      wr_data = $urandom;
      tick();
    end
    idle(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule